// File: doc/BRIEF.md
# Memory Bank Sparing Controller

This block sits between a host memory port and three small banks. Two of the banks hold host data. The third is kept in reserve. Each data bank has its own counter of single-bit correctable errors. When either counter goes past a fixed threshold, the controller stalls the host and copies that bank into the reserve bank one word at a time. Once the copy is complete, it retires the erroring bank and sends every later access for that bank's address range to the reserve. It then records a log entry and switches the status LED from steady on to blinking.

Sparing is allowed only when the first data bank and the reserve bank are both present and mirroring mode is off. Failover happens at most once. If the other data bank later crosses its threshold, that crossing is only logged, with a flag saying no reserve is left. An uncorrectable error report stops the controller for good at any time, including in the middle of a copy. Reported usable capacity never counts the reserve bank.

Top module: `bank_spare_ctrl`

## Requirements
- R1: `spare_avail_o` is 1 exactly when `inst_i[0]` and `inst_i[2]` are 1 and `mirror_i` is 0. `cap_o` equals (`inst_i[0]` + `inst_i[1]`) * DEPTH words, and `inst_i[2]` never adds to it.
- R2: When `ready_o` is 1, a request is accepted. `addr_i[AW]` selects the data bank (0 = first, 1 = second) and `addr_i[AW-1:0]` selects the word. Read data and `rvalid_o` appear one clock after the read is accepted.
- R3: A bank's counter triggers failover only once it exceeds THRESH, which means on the (THRESH+1)-th error. THRESH errors cause no failover. Counters saturate and are cleared by reset.
- R4: During failover, `ready_o` is 0 for exactly 2*DEPTH cycles, and every word of the failing bank is copied to the reserve bank.
- R5: After the copy, `remap_o` is 1 and `failed_bank_o` gives the retired bank. Accesses to that bank's range go to the reserve, which returns the copied data and accepts new writes. The other bank is unaffected. `bank_off_o` has a 1 in the retired bank's bit.
- R6: When failover completes, the log shows `log_valid_o`=1, `log_bank_o` = the retired bank index, `log_done_o`=1 and `log_nospare_o`=0.
- R7: `led_o` is steadily 1 before failover. After failover it toggles every BLINK_DIV cycles.
- R8: A 1 on `ue_i` sets `fatal_o` permanently and holds `ready_o` at 0. If this happens during a copy, the copy is abandoned with no remap and no log.
- R9: A pending threshold crossing does not start a copy while `spare_avail_o` is 0. The crossing stays pending, and the copy starts on the first cycle after `spare_avail_o` becomes 1.
- R10: Once the reserve is in use, a crossing on the other bank only logs `log_bank_o` = that bank, `log_nospare_o`=1 and `log_done_o`=0. The remap and `ready_o` are unchanged.
- R11: If both banks cross in the same cycle, the first bank (index 0) gets the reserve and the second bank is then logged as having no reserve left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| inst_i | input | 3 | Bank present flags; bit 2 is the reserve |
| mirror_i | input | 1 | Mirroring mode active |
| ce_i | input | 2 | Correctable error pulse per data bank |
| ue_i | input | 1 | Uncorrectable error pulse |
| req_i | input | 1 | Host access request |
| we_i | input | 1 | Host write enable |
| addr_i | input | AW+1 | Host address: bank select in top bit |
| wdata_i | input | DW | Host write data |
| ready_o | output | 1 | Host request accepted when 1 |
| rvalid_o | output | 1 | Read data valid |
| rdata_o | output | DW | Read data |
| spare_avail_o | output | 1 | Sparing possible |
| cap_o | output | AW+2 | Usable capacity in words |
| remap_o | output | 1 | Reserve bank in service |
| failed_bank_o | output | 1 | Index of the retired bank |
| bank_off_o | output | 2 | Retired data bank flags |
| log_valid_o | output | 1 | Log record present |
| log_bank_o | output | 1 | Bank index of the log record |
| log_done_o | output | 1 | Log record: copy completed |
| log_nospare_o | output | 1 | Log record: no reserve left |
| led_o | output | 1 | Status LED |
| fatal_o | output | 1 | Sticky fatal halt |

## Verification
A mixed write/read sequence shows that the bank select bit separates the two data banks and that an overwrite replaces old data. Both banks are then filled with distinct patterns, so that a read after failover shows the reserve holding the failing bank's contents while the other bank keeps its own. The error stimulus is run several ways: exactly THRESH errors, a crossing held back by mirroring, a crossing with no reserve installed, crossings on both banks at once, a second crossing after failover, and an uncorrectable error both while idle and during a copy. Each case shows whether the copy started, how long the stall lasted, and what the log and LED show.

// File: rtl/spare_pkg.sv
package spare_pkg;
  typedef enum logic [1:0] {
    ST_NORM = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2,
    ST_HALT = 2'd3
  } ctrl_st_e;
endpackage

// File: rtl/spare_bank_mem.sv
module spare_bank_mem #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          en_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (en_i) begin
      if (we_i) mem_q[addr_i] <= wdata_i;
      else      rdata_o       <= mem_q[addr_i];
    end
  end
endmodule

// File: rtl/spare_err_cnt.sv
module spare_err_cnt #(
  parameter int THRESH = 3
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic inc_i,
  output logic over_o
);
  localparam int CW = $clog2(THRESH + 2);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != '1) cnt_q <= cnt_q + 1'b1;
  end

  assign over_o = cnt_q > CW'(THRESH);
endmodule

// File: rtl/spare_blink.sv
module spare_blink #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tgl_o
);
  localparam int CW = $clog2(DIV + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tgl_o <= 1'b1;
    end else if (cnt_q == CW'(DIV - 1)) begin
      cnt_q <= '0;
      tgl_o <= ~tgl_o;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/bank_spare_ctrl.sv
module bank_spare_ctrl
  import spare_pkg::*;
#(
  parameter int AW        = 3,
  parameter int DW        = 8,
  parameter int THRESH    = 3,
  parameter int BLINK_DIV = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    inst_i,
  input  logic          mirror_i,
  input  logic [1:0]    ce_i,
  input  logic          ue_i,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW:0]   addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          ready_o,
  output logic          rvalid_o,
  output logic [DW-1:0] rdata_o,
  output logic          spare_avail_o,
  output logic [AW+1:0] cap_o,
  output logic          remap_o,
  output logic          failed_bank_o,
  output logic [1:0]    bank_off_o,
  output logic          log_valid_o,
  output logic          log_bank_o,
  output logic          log_done_o,
  output logic          log_nospare_o,
  output logic          led_o,
  output logic          fatal_o
);
  localparam int NB    = 3;
  localparam int SPARE = NB - 1;
  localparam int DEPTH = 1 << AW;

  ctrl_st_e      st_q;
  logic          fatal_q, remap_q, fb_q, cp_bank_q;
  logic [AW-1:0] idx_q;
  logic [1:0]    handled_q, over, pend;
  logic          sel;
  logic          lg_v_q, lg_b_q, lg_d_q, lg_n_q;
  logic          rvalid_q;
  logic [1:0]    rsel_q;
  logic          host_go, lb, tgl;
  logic [AW-1:0] la;
  logic [1:0]    hp, nact;

  logic [NB-1:0]         m_en, m_we;
  logic [NB-1:0][AW-1:0] m_addr;
  logic [NB-1:0][DW-1:0] m_wd, m_rd;

  // banks
  for (genvar g = 0; g < NB; g++) begin : g_bank
    spare_bank_mem #(.AW(AW), .DW(DW)) u_mem (
      .clk_i  (clk_i),
      .en_i   (m_en[g]),
      .we_i   (m_we[g]),
      .addr_i (m_addr[g]),
      .wdata_i(m_wd[g]),
      .rdata_o(m_rd[g])
    );
  end

  // per-bank correctable error counters
  for (genvar g = 0; g < 2; g++) begin : g_cnt
    spare_err_cnt #(.THRESH(THRESH)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (ce_i[g] & ~fatal_q),
      .over_o(over[g])
    );
  end

  spare_blink #(.DIV(BLINK_DIV)) u_blink (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tgl_o (tgl)
  );

  assign spare_avail_o = inst_i[0] & inst_i[2] & ~mirror_i;
  assign nact          = {1'b0, inst_i[0]} + {1'b0, inst_i[1]};
  assign cap_o         = {nact, {AW{1'b0}}};

  assign ready_o = (st_q == ST_NORM);
  assign host_go = req_i & ready_o;
  assign lb      = addr_i[AW];
  assign la      = addr_i[AW-1:0];
  assign hp      = (remap_q && lb == fb_q) ? 2'(SPARE) : {1'b0, lb};
  assign pend    = over & ~handled_q;
  assign sel     = ~pend[0];  // bank 0 wins a tie

  always_comb begin
    m_en   = '0;
    m_we   = '0;
    m_addr = '0;
    m_wd   = '0;
    unique case (st_q)
      ST_NORM: if (host_go) begin
        m_en[hp]   = 1'b1;
        m_we[hp]   = we_i;
        m_addr[hp] = la;
        m_wd[hp]   = wdata_i;
      end
      ST_RD: begin
        m_en[cp_bank_q]   = 1'b1;
        m_addr[cp_bank_q] = idx_q;
      end
      ST_WR: begin
        m_en[SPARE]   = 1'b1;
        m_we[SPARE]   = 1'b1;
        m_addr[SPARE] = idx_q;
        m_wd[SPARE]   = m_rd[cp_bank_q];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rvalid_q <= 1'b0;
      rsel_q   <= '0;
    end else begin
      rvalid_q <= host_go & ~we_i;
      if (host_go && !we_i) rsel_q <= hp;
    end
  end

  always_comb begin
    unique case (rsel_q)
      2'd0:    rdata_o = m_rd[0];
      2'd1:    rdata_o = m_rd[1];
      default: rdata_o = m_rd[SPARE];
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_NORM;
      fatal_q   <= 1'b0;
      remap_q   <= 1'b0;
      fb_q      <= 1'b0;
      cp_bank_q <= 1'b0;
      idx_q     <= '0;
      handled_q <= '0;
      lg_v_q    <= 1'b0;
      lg_b_q    <= 1'b0;
      lg_d_q    <= 1'b0;
      lg_n_q    <= 1'b0;
    end else if (ue_i) begin
      fatal_q <= 1'b1;
      st_q    <= ST_HALT;
    end else begin
      unique case (st_q)
        ST_NORM: if (|pend) begin
          if (remap_q) begin
            handled_q[sel] <= 1'b1;
            lg_v_q <= 1'b1;
            lg_b_q <= sel;
            lg_d_q <= 1'b0;
            lg_n_q <= 1'b1;
          end else if (spare_avail_o) begin
            handled_q[sel] <= 1'b1;
            cp_bank_q      <= sel;
            idx_q          <= '0;
            st_q           <= ST_RD;
          end
        end
        ST_RD: st_q <= ST_WR;
        ST_WR: begin
          if (idx_q == AW'(DEPTH - 1)) begin
            remap_q <= 1'b1;
            fb_q    <= cp_bank_q;
            lg_v_q  <= 1'b1;
            lg_b_q  <= cp_bank_q;
            lg_d_q  <= 1'b1;
            lg_n_q  <= 1'b0;
            st_q    <= ST_NORM;
          end else begin
            idx_q <= idx_q + 1'b1;
            st_q  <= ST_RD;
          end
        end
        default: ;
      endcase
    end
  end

  assign rvalid_o      = rvalid_q;
  assign remap_o       = remap_q;
  assign failed_bank_o = fb_q;
  assign bank_off_o    = remap_q ? (fb_q ? 2'b10 : 2'b01) : 2'b00;
  assign log_valid_o   = lg_v_q;
  assign log_bank_o    = lg_b_q;
  assign log_done_o    = lg_d_q;
  assign log_nospare_o = lg_n_q;
  assign led_o         = remap_q ? tgl : 1'b1;
  assign fatal_o       = fatal_q;
endmodule

// File: rtl/bank_spare_ctrl_chk.sv
module spare_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_i,
  input logic we_i,
  input logic ready_o,
  input logic rvalid_o,
  input logic spare_avail_o,
  input logic remap_o,
  input logic failed_bank_o,
  input logic log_valid_o,
  input logic log_bank_o,
  input logic log_done_o,
  input logic log_nospare_o,
  input logic led_o,
  input logic fatal_o
);
  // R8
  fatal_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |=> fatal_o);
  // R8
  fatal_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fatal_o |-> !ready_o);
  // R10
  remap_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    remap_o |=> remap_o && $stable(failed_bank_o));
  // R7
  led_steady_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !remap_o |-> led_o);
  // R2
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rvalid_o |-> $past(req_i && ready_o && !we_i));
  // R6
  log_on_remap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(remap_o) |-> log_valid_o && log_done_o && !log_nospare_o
                       && (log_bank_o == failed_bank_o));
  // R9
  copy_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(ready_o) && !fatal_o) |-> $past(spare_avail_o));
endmodule

bind bank_spare_ctrl spare_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_i        (req_i),
  .we_i         (we_i),
  .ready_o      (ready_o),
  .rvalid_o     (rvalid_o),
  .spare_avail_o(spare_avail_o),
  .remap_o      (remap_o),
  .failed_bank_o(failed_bank_o),
  .log_valid_o  (log_valid_o),
  .log_bank_o   (log_bank_o),
  .log_done_o   (log_done_o),
  .log_nospare_o(log_nospare_o),
  .led_o        (led_o),
  .fatal_o      (fatal_o)
);

// File: tb/bank_spare_ctrl_tb.sv
module bank_spare_ctrl_tb;
  localparam int CLK_P = 10;
  localparam int AW    = 3;
  localparam int DW    = 8;
  localparam int TH    = 3;
  localparam int BD    = 4;
  localparam int DEPTH = 1 << AW;

  // {we, bank, addr[2:0], wdata[7:0], exp[7:0]}
  localparam int NV = 11;
  localparam logic [20:0] VEC [NV] = '{
    {1'b1, 1'b0, 3'd0, 8'hA1, 8'h00},
    {1'b1, 1'b1, 3'd0, 8'hB2, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h00, 8'hA1},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'hB2},
    {1'b1, 1'b0, 3'd7, 8'hC3, 8'h00},
    {1'b1, 1'b0, 3'd6, 8'hD4, 8'h00},
    {1'b0, 1'b0, 3'd7, 8'h00, 8'hC3},
    {1'b0, 1'b0, 3'd6, 8'h00, 8'hD4},
    {1'b1, 1'b0, 3'd0, 8'hE5, 8'h00},
    {1'b0, 1'b0, 3'd0, 8'h00, 8'hE5},
    {1'b0, 1'b1, 3'd0, 8'h00, 8'hB2}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [2:0]    inst = 3'b111;
  logic          mirror = 1'b0;
  logic [1:0]    ce = 2'b00;
  logic          ue = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW:0]   addr = '0;
  logic [DW-1:0] wdata = '0;
  logic          ready, rvalid, spare_avail, remap, failed_bank;
  logic          log_valid, log_bank, log_done, log_nospare, led, fatal;
  logic [DW-1:0] rdata;
  logic [AW+1:0] cap;
  logic [1:0]    bank_off;

  int checks = 0;
  int errors = 0;

  always #(CLK_P/2) clk = ~clk;

  bank_spare_ctrl #(.AW(AW), .DW(DW), .THRESH(TH), .BLINK_DIV(BD)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .inst_i(inst), .mirror_i(mirror), .ce_i(ce),
    .ue_i(ue), .req_i(req), .we_i(we), .addr_i(addr), .wdata_i(wdata),
    .ready_o(ready), .rvalid_o(rvalid), .rdata_o(rdata),
    .spare_avail_o(spare_avail), .cap_o(cap), .remap_o(remap),
    .failed_bank_o(failed_bank), .bank_off_o(bank_off),
    .log_valid_o(log_valid), .log_bank_o(log_bank), .log_done_o(log_done),
    .log_nospare_o(log_nospare), .led_o(led), .fatal_o(fatal)
  );

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", r, act, exp);
    end
  endtask

  task automatic do_reset(input logic [2:0] i);
    @(negedge clk);
    rst_n = 1'b0; inst = i; mirror = 1'b0; ce = '0; ue = 1'b0; req = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input bit b, input int a, input int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = {b, AW'(a)}; wdata = DW'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(input bit b, input int a, output int d, output int v);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = {b, AW'(a)};
    @(negedge clk);
    d = int'(rdata); v = int'(rvalid);
    req = 1'b0;
  endtask

  task automatic pulse(input logic [1:0] m, input int n);
    repeat (n) begin
      @(negedge clk); ce = m;
      @(negedge clk); ce = 2'b00;
    end
  endtask

  function automatic int pat(input int b, input int i);
    return 8'h30 + 64 * b + i;
  endfunction

  task automatic cfg(input logic [2:0] i, input logic m, input int ea, input int ec);
    @(negedge clk); inst = i; mirror = m; #1;
    chk("R1 spare_avail", int'(spare_avail), ea);
    chk("R1 cap", int'(cap), ec);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int d, v, low, tr;
    logic prev;
    do_reset(3'b111);
    // reset state
    chk("R2 reset ready", int'(ready), 1);
    chk("R2 reset rvalid", int'(rvalid), 0);
    chk("R8 reset fatal", int'(fatal), 0);
    chk("R5 reset remap", int'(remap), 0);
    chk("R5 reset bank_off", int'(bank_off), 0);
    chk("R6 reset log", int'(log_valid), 0);
    chk("R7 reset led", int'(led), 1);

    // R1 availability and capacity
    cfg(3'b001, 1'b0, 0, DEPTH);
    cfg(3'b101, 1'b0, 1, DEPTH);
    cfg(3'b011, 1'b0, 0, 2 * DEPTH);
    cfg(3'b111, 1'b1, 0, 2 * DEPTH);
    cfg(3'b111, 1'b0, 1, 2 * DEPTH);

    // R2 vector table
    for (int k = 0; k < NV; k++) begin
      if (VEC[k][20]) wr(VEC[k][19], int'(VEC[k][18:16]), int'(VEC[k][15:8]));
      else begin
        rd(VEC[k][19], int'(VEC[k][18:16]), d, v);
        chk("R2 rvalid", v, 1);
        chk("R2 rdata", d, int'(VEC[k][7:0]));
      end
    end

    // fill both banks
    for (int b = 0; b < 2; b++)
      for (int i = 0; i < DEPTH; i++) wr(b[0], i, pat(b, i));

    // R3: exactly TH errors, no failover
    pulse(2'b01, TH);
    repeat (5) @(negedge clk);
    chk("R3 ready after TH errors", int'(ready), 1);
    chk("R3 remap after TH errors", int'(remap), 0);

    // R9: crossing held while mirroring
    mirror = 1'b1;
    pulse(2'b01, 1);
    repeat (5) @(negedge clk);
    chk("R9 ready while mirror", int'(ready), 1);
    chk("R9 remap while mirror", int'(remap), 0);
    chk("R7 led steady", int'(led), 1);

    // R4: release, count stall
    @(negedge clk); mirror = 1'b0;
    low = 0;
    repeat (40) begin
      @(negedge clk);
      if (!ready) low++;
    end
    chk("R4 stall cycles", low, 2 * DEPTH);
    chk("R5 remap", int'(remap), 1);
    chk("R5 failed bank", int'(failed_bank), 0);
    chk("R5 bank_off", int'(bank_off), 1);
    chk("R6 log valid", int'(log_valid), 1);
    chk("R6 log bank", int'(log_bank), 0);
    chk("R6 log done", int'(log_done), 1);
    chk("R6 log nospare", int'(log_nospare), 0);

    // R4/R5: copied data served from reserve
    for (int i = 0; i < DEPTH; i++) begin
      rd(1'b0, i, d, v);
      chk("R4 copied word", d, pat(0, i));
    end
    wr(1'b0, 2, 8'h5C);
    rd(1'b0, 2, d, v);
    chk("R5 write after remap", d, 8'h5C);
    rd(1'b1, 5, d, v);
    chk("R5 other bank intact", d, pat(1, 5));

    // R7: blinking
    @(negedge clk); prev = led; tr = 0;
    repeat (4 * BD) begin
      @(negedge clk);
      if (led != prev) tr++;
      prev = led;
    end
    chk("R7 blink toggles", tr, 4);

    // R10: second crossing only logged
    pulse(2'b10, TH + 1);
    repeat (4) @(negedge clk);
    chk("R10 ready", int'(ready), 1);
    chk("R10 failed bank", int'(failed_bank), 0);
    chk("R10 log bank", int'(log_bank), 1);
    chk("R10 log nospare", int'(log_nospare), 1);
    chk("R10 log done", int'(log_done), 0);

    // R11: simultaneous crossings
    do_reset(3'b111);
    pulse(2'b11, TH + 1);
    repeat (40) @(negedge clk);
    chk("R11 remap", int'(remap), 1);
    chk("R11 failed bank", int'(failed_bank), 0);
    chk("R11 log bank", int'(log_bank), 1);
    chk("R11 log nospare", int'(log_nospare), 1);

    // R9: reserve not installed
    do_reset(3'b011);
    pulse(2'b01, TH + 1);
    repeat (30) @(negedge clk);
    chk("R9 no spare remap", int'(remap), 0);
    chk("R9 no spare ready", int'(ready), 1);

    // R8: uncorrectable error mid-copy
    do_reset(3'b111);
    pulse(2'b10, TH + 1);
    while (ready) @(negedge clk);
    repeat (3) @(negedge clk);
    ue = 1'b1;
    @(negedge clk); ue = 1'b0;
    repeat (30) @(negedge clk);
    chk("R8 fatal mid-copy", int'(fatal), 1);
    chk("R8 ready mid-copy", int'(ready), 0);
    chk("R8 no remap", int'(remap), 0);
    chk("R8 no log", int'(log_valid), 0);

    // R8: uncorrectable error while idle
    do_reset(3'b111);
    @(negedge clk); ue = 1'b1;
    @(negedge clk); ue = 1'b0;
    pulse(2'b01, TH + 1);
    repeat (30) @(negedge clk);
    chk("R8 fatal idle", int'(fatal), 1);
    chk("R8 ready idle", int'(ready), 0);
    chk("R8 no failover after fatal", int'(remap), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule